// File: doc/BRIEF.md
# AV Byte-Stream Egress Port

This block is the application-side output of an isochronous audio/video link running in the receive direction. Received packets arrive from an internal buffer as 32-bit words. Each word is flagged as final or not, the final word carries a byte count, and the first word of a packet carries the packet's CRC-error and sequence-error status. The block serialises each word onto a byte-wide bus for an external sink, together with a valid strobe, a start-of-packet strobe and the two status outputs. The sink's ready input passes through one register. The port therefore stops presenting bytes one cycle after the sink lowers ready, and the sink must take a byte in the cycle in which it lowers ready.

The two status pins also act as configuration straps. While reset is asserted their drivers are off. The levels present on them are sampled, and the last value sampled before reset is released sets the little-endian and data-invariant mode bits. The little-endian bit chooses the order in which bytes leave each word. The data-invariant bit is only passed out for the host logic to use.

The controller has four named states:
- `ST_EMPTY`: no word is held.
- `ST_SOP`: the first word of a packet is held and its first byte has not yet been sent.
- `ST_BODY`: a word is held in the middle of a packet.
- `ST_WAIT`: in the middle of a packet, the next word has not yet arrived from the buffer.

Its transitions are:
- **load_first**: `ST_EMPTY` to `ST_SOP`, when a word is available in receive mode.
- **first_sent**: `ST_SOP` to `ST_BODY`, when a byte that is not the packet's last byte is sent.
- **word_refill**: `ST_SOP`/`ST_BODY` to `ST_BODY`, when the last byte of a non-final word is sent and the next word is ready.
- **word_starve**: `ST_SOP`/`ST_BODY` to `ST_WAIT`, the same case when the next word is not ready.
- **resume**: `ST_WAIT` to `ST_BODY`, when the next word arrives.
- **pkt_done**: `ST_SOP`/`ST_BODY` to `ST_EMPTY`, after the packet's last byte, or to `ST_SOP` directly when the next packet's first word is already waiting.

Top module: `av_egress_port`

## Requirements
- R1: While `rst_n` is low, `av_oe` and `err_oe` are 0. After reset, `av_valid` and `av_sync` stay 0 until a packet word has been offered on the buffer side.
- R2: `mode_le` equals the level of `crc_pad_i`, and `mode_dinv` the level of `seq_pad_i`, as sampled at the last clock edge while `rst_n` is low. Both hold that value while `rst_n` stays high.
- R3: With `mode_le`=1, the bytes of a word leave in the order bits [7:0], [15:8], [23:16], [31:24]. With `mode_le`=0, they leave in the order [31:24], [23:16], [15:8], [7:0].
- R4: A word with `buf_last`=0 yields 4 bytes. A word with `buf_last`=1 yields `buf_cnt` bytes, where a `buf_cnt` of 0 means 4.
- R5: `av_valid` is 1 only in a cycle whose previous cycle had `sink_ready`=1. Every cycle with `av_valid`=1 transfers one byte.
- R6: `av_sync` goes high while a packet's first byte is pending, stays high until that byte is transferred, and is high with `av_valid` for exactly one cycle per packet, the cycle of the first byte.
- R7: For every byte of a packet, `err_crc_o` and `err_seq_o` equal the `buf_crc` and `buf_seq` flags given with that packet's first word. They change only when the next packet starts.
- R8: With `cfg_dir_tx`=1 (transmit), `av_valid`, `buf_pop`, `av_oe` and `err_oe` are 0. With `cfg_dir_tx`=0 (receive, the reset value of the owning control bit), the port streams normally.
- R9: If the buffer runs empty in the middle of a packet, `av_valid` stays 0 until the next word arrives. The stream then resumes with no byte lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low, asynchronous |
| cfg_dir_tx | input | 1 | Direction: 1 transmit (port idle), 0 receive |
| buf_valid | input | 1 | Buffer has a word at its head |
| buf_word | input | 32 | Word at the buffer head |
| buf_last | input | 1 | Head word is the packet's final word |
| buf_cnt | input | 2 | Byte count of the final word, 0 means 4 |
| buf_crc | input | 1 | CRC-error status, valid with the packet's first word |
| buf_seq | input | 1 | Sequence-error status, valid with the packet's first word |
| buf_pop | output | 1 | Consumes the head word at the clock edge |
| sink_ready | input | 1 | Sink can accept bytes |
| av_data | output | 8 | Byte to the sink |
| av_valid | output | 1 | `av_data` is valid and is transferred |
| av_sync | output | 1 | Start of packet |
| av_oe | output | 1 | Output enable for the data, valid and sync pins |
| err_crc_o | output | 1 | CRC-error flag of the current packet |
| err_seq_o | output | 1 | Sequence-error flag of the current packet |
| err_oe | output | 1 | Output enable for the two error pins |
| crc_pad_i | input | 1 | Level read back from the CRC-error pin (strap) |
| seq_pad_i | input | 1 | Level read back from the sequence-error pin (strap) |
| mode_le | output | 1 | Little-endian mode bit |
| mode_dinv | output | 1 | Data-invariant mode bit |

## Verification
The assertions assume the buffer follows show-ahead semantics: the head word stays unchanged until it is popped. They also assume the status flags are presented with each packet's first word, and that the straps are held steady for at least one clock before reset is released. The bench's buffer model feeds the head word from a queue that advances only on `buf_pop`, and attaches the status to every word of a packet. It sets both pad levels several cycles before it releases reset. Its sink sets `sink_ready` between edges under four fixed patterns, and it leaves gaps between words to starve the port mid-packet.

// File: rtl/av_egress_pkg.sv
package av_egress_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_SOP   = 2'd1,
        ST_BODY  = 2'd2,
        ST_WAIT  = 2'd3
    } egress_state_t;

endpackage

// File: rtl/av_strap_latch.sv
module av_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic crc_pad_i,
    input  logic seq_pad_i,
    output logic mode_le,
    output logic mode_dinv
);

    // Pads are sampled on every edge while reset is held; the last
    // sample before release is kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_le   <= crc_pad_i;
            mode_dinv <= seq_pad_i;
        end
    end

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(mode_le) && $stable(mode_dinv)));

endmodule

// File: rtl/av_ready_stage.sv
module av_ready_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic sink_ready,
    output logic rdy_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= sink_ready;
    end

endmodule

// File: rtl/av_lane_pick.sv
module av_lane_pick #(
    parameter int WB = 4,
    parameter int BW = 8,
    localparam int DW = WB * BW,
    localparam int CW = (WB > 1) ? $clog2(WB) : 1
) (
    input  logic [DW-1:0] word,
    input  logic [CW-1:0] idx,
    input  logic          le,
    output logic [BW-1:0] lane
);

    logic [BW-1:0] le_lane [WB];
    logic [BW-1:0] be_lane [WB];

    for (genvar k = 0; k < WB; k++) begin : g_lane
        assign le_lane[k] = word[k*BW +: BW];
        assign be_lane[k] = word[(WB-1-k)*BW +: BW];
    end

    always_comb begin
        lane = le ? le_lane[idx] : be_lane[idx];
    end

endmodule

// File: rtl/av_egress_fsm.sv
module av_egress_fsm
    import av_egress_pkg::*;
#(
    parameter int WB = 4,
    parameter int BW = 8,
    localparam int DW = WB * BW,
    localparam int CW = (WB > 1) ? $clog2(WB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic          rdy_q,
    input  logic          buf_valid,
    input  logic [DW-1:0] buf_word,
    input  logic          buf_last,
    input  logic [CW-1:0] buf_cnt,
    input  logic          buf_crc,
    input  logic          buf_seq,
    output logic          buf_pop,
    output logic [DW-1:0] hold_word,
    output logic [CW-1:0] byte_idx,
    output logic          out_valid,
    output logic          out_sync,
    output logic          err_crc,
    output logic          err_seq
);

    egress_state_t state, nstate;
    logic          hold_last;
    logic [CW-1:0] hold_cnt;
    logic [CW-1:0] end_idx;
    logic          held;
    logic          xfer;
    logic          word_end;
    logic          load_first;

    always_comb begin
        end_idx  = (hold_last && hold_cnt != '0) ? hold_cnt - 1'b1 : CW'(WB - 1);
        held     = (state == ST_SOP) || (state == ST_BODY);
        xfer     = held && rx_en && rdy_q;
        word_end = (byte_idx == end_idx);
    end

    // Transition logic
    always_comb begin
        nstate     = state;
        buf_pop    = 1'b0;
        load_first = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                if (rx_en && buf_valid) begin
                    buf_pop    = 1'b1;
                    load_first = 1'b1;
                    nstate     = ST_SOP;
                end
            end
            ST_SOP, ST_BODY: begin
                if (xfer) begin
                    if (!word_end) begin
                        nstate = ST_BODY;
                    end else if (hold_last) begin
                        if (buf_valid) begin
                            buf_pop    = 1'b1;
                            load_first = 1'b1;
                            nstate     = ST_SOP;
                        end else begin
                            nstate = ST_EMPTY;
                        end
                    end else if (buf_valid) begin
                        buf_pop = 1'b1;
                        nstate  = ST_BODY;
                    end else begin
                        nstate = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (rx_en && buf_valid) begin
                    buf_pop = 1'b1;
                    nstate  = ST_BODY;
                end
            end
            default: nstate = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= nstate;
    end

    // Holding register, byte pointer and packet status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_word <= '0;
            hold_last <= 1'b0;
            hold_cnt  <= '0;
            byte_idx  <= '0;
            err_crc   <= 1'b0;
            err_seq   <= 1'b0;
        end else begin
            if (buf_pop) begin
                hold_word <= buf_word;
                hold_last <= buf_last;
                hold_cnt  <= buf_cnt;
                byte_idx  <= '0;
            end else if (xfer) begin
                byte_idx <= byte_idx + 1'b1;
            end
            if (load_first) begin
                err_crc <= buf_crc;
                err_seq <= buf_seq;
            end
        end
    end

    // Outputs
    always_comb begin
        out_valid = xfer;
        out_sync  = rx_en && (state == ST_SOP);
    end

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> (byte_idx <= end_idx));

    // R6
    sop_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOP && xfer && !(word_end && hold_last)) |=> (state == ST_BODY || state == ST_WAIT));

    // R9
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !out_valid);

endmodule

// File: rtl/av_egress_port.sv
module av_egress_port #(
    parameter int WB = 4,
    parameter int BW = 8,
    localparam int DW = WB * BW,
    localparam int CW = (WB > 1) ? $clog2(WB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_dir_tx,
    input  logic          buf_valid,
    input  logic [DW-1:0] buf_word,
    input  logic          buf_last,
    input  logic [CW-1:0] buf_cnt,
    input  logic          buf_crc,
    input  logic          buf_seq,
    output logic          buf_pop,
    input  logic          sink_ready,
    output logic [BW-1:0] av_data,
    output logic          av_valid,
    output logic          av_sync,
    output logic          av_oe,
    output logic          err_crc_o,
    output logic          err_seq_o,
    output logic          err_oe,
    input  logic          crc_pad_i,
    input  logic          seq_pad_i,
    output logic          mode_le,
    output logic          mode_dinv
);

    logic          rx_en;
    logic          rdy_q;
    logic [DW-1:0] hold_word;
    logic [CW-1:0] byte_idx;

    assign rx_en  = !cfg_dir_tx;
    assign av_oe  = rst_n && rx_en;
    assign err_oe = rst_n && rx_en;

    av_strap_latch u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .crc_pad_i (crc_pad_i),
        .seq_pad_i (seq_pad_i),
        .mode_le   (mode_le),
        .mode_dinv (mode_dinv)
    );

    av_ready_stage u_rdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .sink_ready (sink_ready),
        .rdy_q      (rdy_q)
    );

    av_egress_fsm #(.WB(WB), .BW(BW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .rdy_q     (rdy_q),
        .buf_valid (buf_valid),
        .buf_word  (buf_word),
        .buf_last  (buf_last),
        .buf_cnt   (buf_cnt),
        .buf_crc   (buf_crc),
        .buf_seq   (buf_seq),
        .buf_pop   (buf_pop),
        .hold_word (hold_word),
        .byte_idx  (byte_idx),
        .out_valid (av_valid),
        .out_sync  (av_sync),
        .err_crc   (err_crc_o),
        .err_seq   (err_seq_o)
    );

    av_lane_pick #(.WB(WB), .BW(BW)) u_lane (
        .word (hold_word),
        .idx  (byte_idx),
        .le   (mode_le),
        .lane (av_data)
    );

    // R5
    rdy_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        av_valid |-> $past(sink_ready));

    // R6
    sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (av_sync && !av_valid) |=> (av_sync || cfg_dir_tx));

    // R7
    err_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (av_valid && !av_sync) |-> ($stable(err_crc_o) && $stable(err_seq_o)));

    // R8
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_dir_tx |-> (!av_valid && !buf_pop && !av_oe));

    // R1
    always_comb begin
        if (!rst_n) begin
            rst_oe_chk: assert (!err_oe && !av_oe);
        end
    end

endmodule

// File: tb/sim_av_egress_port.sv
module sim_av_egress_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_dir_tx = 1'b0;
    logic        buf_valid;
    logic [31:0] buf_word;
    logic        buf_last;
    logic [1:0]  buf_cnt;
    logic        buf_crc;
    logic        buf_seq;
    logic        buf_pop;
    logic        sink_ready = 1'b0;
    logic [7:0]  av_data;
    logic        av_valid, av_sync, av_oe;
    logic        err_crc_o, err_seq_o, err_oe;
    logic        crc_pad_i = 1'b0;
    logic        seq_pad_i = 1'b0;
    logic        mode_le, mode_dinv;

    always #5 clk = ~clk;

    av_egress_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_dir_tx(cfg_dir_tx),
        .buf_valid(buf_valid), .buf_word(buf_word), .buf_last(buf_last),
        .buf_cnt(buf_cnt), .buf_crc(buf_crc), .buf_seq(buf_seq),
        .buf_pop(buf_pop), .sink_ready(sink_ready), .av_data(av_data),
        .av_valid(av_valid), .av_sync(av_sync), .av_oe(av_oe),
        .err_crc_o(err_crc_o), .err_seq_o(err_seq_o), .err_oe(err_oe),
        .crc_pad_i(crc_pad_i), .seq_pad_i(seq_pad_i),
        .mode_le(mode_le), .mode_dinv(mode_dinv)
    );

    // Buffer model: show-ahead queue advanced by buf_pop
    logic [31:0] q_word [0:511];
    logic        q_last [0:511];
    logic [1:0]  q_cnt  [0:511];
    logic        q_crc  [0:511];
    logic        q_seq  [0:511];
    int          q_wr = 0;
    int          q_rd = 0;

    assign buf_valid = (q_rd < q_wr);
    assign buf_word  = q_word[q_rd[8:0]];
    assign buf_last  = q_last[q_rd[8:0]];
    assign buf_cnt   = q_cnt[q_rd[8:0]];
    assign buf_crc   = q_crc[q_rd[8:0]];
    assign buf_seq   = q_seq[q_rd[8:0]];

    always @(posedge clk) begin
        if (rst_n && buf_pop) q_rd <= q_rd + 1;
    end

    // Expected byte stream
    logic [7:0] e_byte [0:1023];
    logic       e_sync [0:1023];
    logic       e_crc  [0:1023];
    logic       e_seq  [0:1023];
    int         e_wr = 0;
    int         e_rd = 0;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    int rmode = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Sink: ready pattern set between edges
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rmode)
            0: sink_ready <= 1'b1;
            1: sink_ready <= cyc[0];
            2: sink_ready <= lfsr[0];
            default: sink_ready <= (cyc % 5 == 0);
        endcase
    end

    // Monitor
    logic ready_prev = 1'b0;
    logic sync_stall = 1'b0;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ready_prev = 1'b0;
            sync_stall = 1'b0;
        end else begin
            if (av_valid) begin
                // R5: valid needs ready in the previous cycle
                chk(ready_prev, "R5 ready pipeline", {31'd0, ready_prev}, 32'd1);
                if (e_rd < e_wr) begin
                    // R3 R4 R9: byte order, counts, no loss across starved words
                    chk(av_data == e_byte[e_rd], "R3/R4/R9 data", {24'd0, av_data}, {24'd0, e_byte[e_rd]});
                    // R6: sync with valid only on the first byte
                    chk(av_sync == e_sync[e_rd], "R6 sync", {31'd0, av_sync}, {31'd0, e_sync[e_rd]});
                    // R7: status for every byte
                    chk(err_crc_o == e_crc[e_rd] && err_seq_o == e_seq[e_rd], "R7 status",
                        {30'd0, err_crc_o, err_seq_o}, {30'd0, e_crc[e_rd], e_seq[e_rd]});
                    e_rd++;
                end else begin
                    chk(1'b0, "R4 extra byte", {24'd0, av_data}, 32'd0);
                end
            end
            if (sync_stall) begin
                // R6: sync held until first byte moves
                chk(av_sync || cfg_dir_tx, "R6 sync hold", {31'd0, av_sync}, 32'd1);
            end
            if (cfg_dir_tx) begin
                // R8: transmit direction keeps the port quiet
                chk(!av_valid && !buf_pop, "R8 tx quiet", {30'd0, av_valid, buf_pop}, 32'd0);
            end
            ready_prev = sink_ready;
            sync_stall = av_sync && !av_valid;
        end
    end

    function automatic logic [7:0] pat(input int pid, input int i);
        return 8'((pid * 37 + i * 11 + 1) & 8'hFF);
    endfunction

    task automatic push_pkt(input int pid, input int len, input logic le, input bit gaps);
        int nw;
        nw = (len + 3) / 4;
        for (int i = 0; i < len; i++) begin
            e_byte[e_wr] = pat(pid, i);
            e_sync[e_wr] = (i == 0);
            e_crc[e_wr]  = pid[0];
            e_seq[e_wr]  = pid[1];
            e_wr++;
        end
        for (int w = 0; w < nw; w++) begin
            logic [31:0] wd;
            wd = '0;
            for (int k = 0; k < 4; k++) begin
                logic [7:0] b;
                b = (4 * w + k < len) ? pat(pid, 4 * w + k) : 8'h00;
                if (le) wd[8*k +: 8] = b;
                else    wd[8*(3-k) +: 8] = b;
            end
            q_word[q_wr] = wd;
            q_last[q_wr] = (w == nw - 1);
            q_cnt[q_wr]  = 2'(len % 4);
            q_crc[q_wr]  = pid[0];
            q_seq[q_wr]  = pid[1];
            q_wr++;
            if (gaps) repeat (3) @(negedge clk);
        end
    endtask

    task automatic drain;
        int t;
        t = 0;
        while ((e_rd < e_wr) && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk(e_rd == e_wr, "R9 drain complete", 32'(e_rd), 32'(e_wr));
    endtask

    task automatic do_reset(input logic le_pad, input logic dinv_pad);
        @(negedge clk);
        rst_n = 1'b0;
        crc_pad_i = le_pad;
        seq_pad_i = dinv_pad;
        q_rd = q_wr;
        e_rd = e_wr;
        repeat (3) @(negedge clk);
        // R1: drivers off during reset
        chk(!av_oe && !err_oe, "R1 oe in reset", {30'd0, av_oe, err_oe}, 32'd0);
        rst_n = 1'b1;
        crc_pad_i = ~le_pad;
        seq_pad_i = ~dinv_pad;
        @(negedge clk);
        // R2: straps keep the level seen during reset
        chk(mode_le == le_pad, "R2 little-endian strap", {31'd0, mode_le}, {31'd0, le_pad});
        chk(mode_dinv == dinv_pad, "R2 data-invariant strap", {31'd0, mode_dinv}, {31'd0, dinv_pad});
        // R1: idle outputs, drivers on in receive
        chk(!av_valid && !av_sync, "R1 idle after reset", {30'd0, av_valid, av_sync}, 32'd0);
        chk(av_oe && err_oe, "R8 oe in receive", {30'd0, av_oe, err_oe}, 32'd3);
        repeat (4) @(negedge clk);
        chk(mode_le == le_pad && mode_dinv == dinv_pad, "R2 strap hold",
            {30'd0, mode_le, mode_dinv}, {30'd0, le_pad, dinv_pad});
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int pid;
        pid = 0;
        for (int le = 0; le < 2; le++) begin
            do_reset(1'(le), 1'(~le));
            for (int rm = 0; rm < 4; rm++) begin
                rmode = rm;
                for (int len = 1; len <= 12; len++) begin
                    push_pkt(pid, len, 1'(le), rm[0]);
                    pid++;
                end
                drain();
                @(negedge clk);
                chk(!av_valid && !av_sync, "R6 idle after stream", {30'd0, av_valid, av_sync}, 32'd0);
            end
            // R8: transmit direction withholds queued data
            rmode = 0;
            @(negedge clk);
            cfg_dir_tx = 1'b1;
            push_pkt(pid, 7, 1'(le), 1'b0);
            pid++;
            repeat (10) @(negedge clk);
            chk(!av_oe && !err_oe, "R8 oe off in tx", {30'd0, av_oe, err_oe}, 32'd0);
            chk(q_rd < q_wr, "R8 no pop in tx", 32'(q_rd), 32'(q_wr));
            cfg_dir_tx = 1'b0;
            drain();
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule